// File: doc/BRIEF.md
# Out-of-Order Instruction Window

This block tracks every instruction that has been dispatched but has not finished. Each live instruction holds one slot. The slot keeps an opaque payload, an instruction class and a count of the vector elements still to do. A new instruction always takes the lowest-numbered free slot. The caller gets that slot back as a one-hot tag, one bit per slot. Execution units name a slot by that tag when they send a completion notice.

A completion notice carries the pipeline stage the instruction has reached and the number of elements it has just finished. Each class has its own no-return stage, set by a parameter. At or beyond that stage the slot is freed at once, whatever its age, and the instruction is never issued again. Below that stage the slot stays and its remaining-element count drops by the number finished, stopping at zero.

The window contents are part of the saved processor context when an interrupt is taken:

- A save request streams the live slots out one per cycle and empties the window.
- A restore request accepts entries of the same format and writes them back.
- The block then pulses a done flag and reissues every entry that is still live, one per cycle.
- A restored vector operation carries its remaining count, so it resumes mid-vector.

Top module: `iw_window`

## Requirements
- R1: A dispatch (`disp_valid` high while `disp_ready` is high) writes into the lowest-numbered free slot. `disp_tag` shows that slot as a one-hot vector, with bit i meaning slot i. A slot is never overwritten while it is occupied.
- R2: When all slots are occupied, `win_full` is high and `disp_ready` is low, and a dispatch attempt changes nothing.
- R3: A completion whose `cmpl_stage` is at or above its class's no-return stage frees the tagged slot, whatever its age. That slot becomes the next dispatch target if it is the lowest free slot.
- R4: A completion whose stage is below the no-return stage keeps the slot. It lowers the slot's remaining count by `cmpl_elems`, and the count stops at zero.
- R5: The no-return stage of each class comes from parameter `NRP_TAB`, with class c held in bits [c*SW +: SW]. The defaults are: class 0 at stage 1, class 1 at stage 2, class 2 at stage 3 and class 3 at stage 3.
- R6: A dispatch and a completion that frees a different slot, both in the same cycle, both take effect.
- R7: A save starts when `irq_save` is seen in idle. From the next cycle, the occupied slots stream out one per cycle, lowest first, on `sv_*`. `sv_last` marks the final beat, and each emitted slot is freed. An empty window gives no beats and returns to idle.
- R8: `disp_ready` is low whenever the block is saving, restoring, signalling done or replaying.
- R9: After `irq_restore` in idle, each `rs_valid` beat is written into the lowest free slot, in arrival order. One cycle after the beat that carries `rs_last`, `rs_done` is high for exactly one cycle.
- R10: Starting the cycle after `rs_done`, every occupied slot is reissued on `rp_*`, lowest first and one per cycle. `rp_tag` is the one-hot slot tag and `rp_vlen` is the remaining count. A reissued slot stays occupied.
- R11: Completion notices are ignored while saving or restoring.
- R12: A slot freed by a completion before its reissue turn is not reissued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_payload | input | DW | Instruction payload |
| disp_cls | input | CW | Instruction class |
| disp_vlen | input | VW | Vector elements to do |
| disp_ready | output | 1 | Dispatch can be accepted |
| disp_tag | output | N | One-hot slot the next dispatch takes |
| win_full | output | 1 | All slots occupied |
| cmpl_valid | input | 1 | Completion notice |
| cmpl_tag | input | N | One-hot slot of the notice |
| cmpl_stage | input | SW | Stage reached |
| cmpl_elems | input | VW | Elements just finished |
| irq_save | input | 1 | Start context save |
| irq_restore | input | 1 | Start context restore |
| sv_valid | output | 1 | Save beat valid |
| sv_last | output | 1 | Final save beat |
| sv_payload | output | DW | Saved payload |
| sv_cls | output | CW | Saved class |
| sv_vlen | output | VW | Saved remaining count |
| rs_valid | input | 1 | Restore beat valid |
| rs_last | input | 1 | Final restore beat |
| rs_payload | input | DW | Restored payload |
| rs_cls | input | CW | Restored class |
| rs_vlen | input | VW | Restored remaining count |
| rs_done | output | 1 | Restore finished pulse |
| rp_valid | output | 1 | Reissue beat valid |
| rp_tag | output | N | One-hot slot being reissued |
| rp_payload | output | DW | Reissued payload |
| rp_cls | output | CW | Reissued class |
| rp_vlen | output | VW | Reissued remaining count |

## Verification
The bench frees slots out of age order and then checks that the next dispatch lands in the hole. A design that allocated at a wrapping pointer would return the wrong tag there.

It sends notices just below and exactly at each class's no-return stage. An off-by-one comparison would either free a slot too early or leave it stuck until the save stream.

It sends a completion while saving and while restoring. It sends another in the very cycle `rs_done` is high. It also lets a vector count run past zero.

A design that honoured those notices would drop or keep the wrong entries in the save or reissue streams. One that reissued a freed slot, or wrapped the count, would show it in `rp_*` and `sv_vlen`.

// File: rtl/iw_pkg.sv
package iw_pkg;

  typedef enum logic [2:0] {
    M_IDLE    = 3'd0,
    M_SAVE    = 3'd1,
    M_RESTORE = 3'd2,
    M_DONE    = 3'd3,
    M_REPLAY  = 3'd4
  } iw_mode_e;

endpackage

// File: rtl/iw_pick.sv
module iw_pick #(
  parameter int N = 8
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic         any
);

  always_comb begin
    gnt = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt    = '0;
        gnt[i] = 1'b1;
      end
    end
  end

  assign any = |req;

endmodule

// File: rtl/iw_slot.sv
module iw_slot #(
  parameter int DW = 16,
  parameter int CW = 2,
  parameter int VW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_payload,
  input  logic [CW-1:0] wr_cls,
  input  logic [VW-1:0] wr_vlen,
  input  logic          clr,
  input  logic          prog_en,
  input  logic [VW-1:0] prog_elems,
  output logic          occ,
  output logic [DW-1:0] payload,
  output logic [CW-1:0] cls,
  output logic [VW-1:0] vlen
);

  function automatic logic [VW-1:0] vlen_after(input logic [VW-1:0] cur,
                                               input logic [VW-1:0] done);
    if (done >= cur) return '0;
    return cur - done;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ     <= 1'b0;
      payload <= '0;
      cls     <= '0;
      vlen    <= '0;
    end else if (wr_en) begin
      occ     <= 1'b1;
      payload <= wr_payload;
      cls     <= wr_cls;
      vlen    <= wr_vlen;
    end else if (clr) begin
      occ <= 1'b0;
    end else if (prog_en) begin
      vlen <= vlen_after(vlen, prog_elems);
    end
  end

  // R1
  no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !occ);

  // R4
  vlen_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occ && !$past(wr_en) && $past(occ)) |-> (vlen <= $past(vlen)));

endmodule

// File: rtl/iw_ctrl.sv
module iw_ctrl
  import iw_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     irq_save,
  input  logic     irq_restore,
  input  logic     save_end,
  input  logic     rs_end,
  input  logic     rp_end,
  output iw_mode_e mode
);

  iw_mode_e nxt;

  always_comb begin
    nxt = mode;
    unique case (mode)
      M_IDLE: begin
        if (irq_save)         nxt = M_SAVE;
        else if (irq_restore) nxt = M_RESTORE;
      end
      M_SAVE:    if (save_end) nxt = M_IDLE;
      M_RESTORE: if (rs_end)   nxt = M_DONE;
      M_DONE:                  nxt = M_REPLAY;
      M_REPLAY:  if (rp_end)   nxt = M_IDLE;
      default:                 nxt = M_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mode <= M_IDLE;
    else        mode <= nxt;
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_DONE) |=> (mode == M_REPLAY));

  // R9
  done_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_DONE) |-> ($past(mode) == M_RESTORE));

endmodule

// File: rtl/iw_window.sv
module iw_window
  import iw_pkg::*;
#(
  parameter int N  = 8,
  parameter int DW = 16,
  parameter int CW = 2,
  parameter int VW = 6,
  parameter int SW = 2,
  parameter logic [(2**CW)*SW-1:0] NRP_TAB = {2'd3, 2'd3, 2'd2, 2'd1}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          disp_valid,
  input  logic [DW-1:0] disp_payload,
  input  logic [CW-1:0] disp_cls,
  input  logic [VW-1:0] disp_vlen,
  output logic          disp_ready,
  output logic [N-1:0]  disp_tag,
  output logic          win_full,
  input  logic          cmpl_valid,
  input  logic [N-1:0]  cmpl_tag,
  input  logic [SW-1:0] cmpl_stage,
  input  logic [VW-1:0] cmpl_elems,
  input  logic          irq_save,
  input  logic          irq_restore,
  output logic          sv_valid,
  output logic          sv_last,
  output logic [DW-1:0] sv_payload,
  output logic [CW-1:0] sv_cls,
  output logic [VW-1:0] sv_vlen,
  input  logic          rs_valid,
  input  logic          rs_last,
  input  logic [DW-1:0] rs_payload,
  input  logic [CW-1:0] rs_cls,
  input  logic [VW-1:0] rs_vlen,
  output logic          rs_done,
  output logic          rp_valid,
  output logic [N-1:0]  rp_tag,
  output logic [DW-1:0] rp_payload,
  output logic [CW-1:0] rp_cls,
  output logic [VW-1:0] rp_vlen
);

  function automatic logic [SW-1:0] nrp_of(input logic [CW-1:0] c);
    return NRP_TAB[int'(c) * SW +: SW];
  endfunction

  function automatic logic past_nrp(input logic [SW-1:0] stage,
                                    input logic [CW-1:0] c);
    return stage >= nrp_of(c);
  endfunction

  iw_mode_e mode;

  logic [N-1:0]  occ_vec;
  logic [DW-1:0] pl_arr  [N];
  logic [CW-1:0] cls_arr [N];
  logic [VW-1:0] vl_arr  [N];

  logic [N-1:0] free_gnt, save_gnt, rp_req, rp_gnt, pend;
  logic         free_any, save_any, rp_any;
  logic [N-1:0] wr_vec, retire_vec, prog_vec, clr_vec;

  // named internal events
  logic wr_go, cmpl_ok, save_fire, save_end, rs_end, rp_end;

  logic [DW-1:0] wr_payload;
  logic [CW-1:0] wr_cls;
  logic [VW-1:0] wr_vlen;

  iw_pick #(.N(N)) u_free (.req(~occ_vec),       .gnt(free_gnt), .any(free_any));
  iw_pick #(.N(N)) u_save (.req(occ_vec),        .gnt(save_gnt), .any(save_any));
  iw_pick #(.N(N)) u_rp   (.req(rp_req),         .gnt(rp_gnt),   .any(rp_any));

  assign rp_req  = pend & occ_vec;
  assign cmpl_ok = cmpl_valid && (mode != M_SAVE) && (mode != M_RESTORE);
  assign wr_go   = ((mode == M_IDLE) && disp_valid && free_any) ||
                   ((mode == M_RESTORE) && rs_valid && free_any);

  assign wr_payload = (mode == M_RESTORE) ? rs_payload : disp_payload;
  assign wr_cls     = (mode == M_RESTORE) ? rs_cls     : disp_cls;
  assign wr_vlen    = (mode == M_RESTORE) ? rs_vlen    : disp_vlen;

  assign save_fire = (mode == M_SAVE) && save_any;
  assign sv_valid  = save_fire;
  assign sv_last   = save_fire && ($countones(occ_vec) == 1);
  assign save_end  = !save_any || sv_last;
  assign rs_end    = rs_valid && rs_last;
  assign rp_end    = $countones(rp_req) <= 1;

  assign disp_ready = (mode == M_IDLE) && free_any;
  assign disp_tag   = free_gnt;
  assign win_full   = &occ_vec;
  assign rs_done    = (mode == M_DONE);
  assign rp_valid   = (mode == M_REPLAY) && rp_any;
  assign rp_tag     = rp_valid ? rp_gnt : '0;

  for (genvar i = 0; i < N; i++) begin : g_slot
    logic hit;
    assign hit           = cmpl_ok && cmpl_tag[i] && occ_vec[i];
    assign retire_vec[i] = hit && past_nrp(cmpl_stage, cls_arr[i]);
    assign prog_vec[i]   = hit && !past_nrp(cmpl_stage, cls_arr[i]);
    assign wr_vec[i]     = wr_go && free_gnt[i];
    assign clr_vec[i]    = retire_vec[i] || (save_fire && save_gnt[i]);

    iw_slot #(.DW(DW), .CW(CW), .VW(VW)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_vec[i]),
      .wr_payload (wr_payload),
      .wr_cls     (wr_cls),
      .wr_vlen    (wr_vlen),
      .clr        (clr_vec[i]),
      .prog_en    (prog_vec[i]),
      .prog_elems (cmpl_elems),
      .occ        (occ_vec[i]),
      .payload    (pl_arr[i]),
      .cls        (cls_arr[i]),
      .vlen       (vl_arr[i])
    );
  end

  always_comb begin
    sv_payload = '0; sv_cls = '0; sv_vlen = '0;
    rp_payload = '0; rp_cls = '0; rp_vlen = '0;
    for (int i = 0; i < N; i++) begin
      if (save_gnt[i]) begin
        sv_payload = pl_arr[i]; sv_cls = cls_arr[i]; sv_vlen = vl_arr[i];
      end
      if (rp_gnt[i]) begin
        rp_payload = pl_arr[i]; rp_cls = cls_arr[i]; rp_vlen = vl_arr[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 pend <= '0;
    else if (mode == M_DONE)    pend <= occ_vec & ~retire_vec;
    else if (mode == M_REPLAY)  pend <= pend & ~rp_gnt;
    else                        pend <= '0;
  end

  iw_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_save    (irq_save),
    .irq_restore (irq_restore),
    .save_end    (save_end),
    .rs_end      (rs_end),
    .rp_end      (rp_end),
    .mode        (mode)
  );

  // R2
  full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_full |-> !disp_ready);

  // R8
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != M_IDLE) |-> !disp_ready);

  // R7
  save_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sv_valid |=> ((occ_vec & $past(save_gnt)) == '0));

  // R10
  rp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rp_tag) && (rp_valid == (rp_tag != '0)));

  // R11
  hold_cmpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == M_SAVE) || (mode == M_RESTORE)) |-> (retire_vec == '0 && prog_vec == '0));

endmodule

// File: tb/iw_window_tb.sv
module iw_window_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        disp_valid = 1'b0;
  logic [15:0] disp_payload = '0;
  logic [1:0]  disp_cls = '0;
  logic [5:0]  disp_vlen = '0;
  logic        disp_ready;
  logic [7:0]  disp_tag;
  logic        win_full;
  logic        cmpl_valid = 1'b0;
  logic [7:0]  cmpl_tag = '0;
  logic [1:0]  cmpl_stage = '0;
  logic [5:0]  cmpl_elems = '0;
  logic        irq_save = 1'b0;
  logic        irq_restore = 1'b0;
  logic        sv_valid, sv_last;
  logic [15:0] sv_payload;
  logic [1:0]  sv_cls;
  logic [5:0]  sv_vlen;
  logic        rs_valid = 1'b0;
  logic        rs_last = 1'b0;
  logic [15:0] rs_payload = '0;
  logic [1:0]  rs_cls = '0;
  logic [5:0]  rs_vlen = '0;
  logic        rs_done;
  logic        rp_valid;
  logic [7:0]  rp_tag;
  logic [15:0] rp_payload;
  logic [1:0]  rp_cls;
  logic [5:0]  rp_vlen;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  iw_window u_dut (.*);

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic dispatch(input logic [15:0] p, input logic [1:0] c,
                          input logic [5:0] v, input logic [7:0] exp_tag);
    disp_valid = 1'b1; disp_payload = p; disp_cls = c; disp_vlen = v;
    #1 chk(disp_tag == exp_tag, "R1", "dispatch tag", disp_tag, exp_tag);
    @(negedge clk);
    disp_valid = 1'b0;
  endtask

  task automatic complete(input int slot, input logic [1:0] st, input logic [5:0] el);
    cmpl_valid = 1'b1; cmpl_tag = 8'(1 << slot); cmpl_stage = st; cmpl_elems = el;
    @(negedge clk);
    cmpl_valid = 1'b0; cmpl_tag = '0;
  endtask

  task automatic t_reset;
    #1;
    chk(disp_ready == 1'b1, "R1", "reset ready", disp_ready, 1);
    chk(disp_tag == 8'h01, "R1", "reset tag", disp_tag, 8'h01);
    chk(win_full == 1'b0, "R2", "reset full", win_full, 0);
    chk(sv_valid == 1'b0 && rp_valid == 1'b0 && rs_done == 1'b0, "R9",
        "reset stream outputs", {sv_valid, rp_valid, rs_done}, 0);
  endtask

  task automatic t_fill;
    for (int i = 0; i < 8; i++)
      dispatch(16'h0100 + 16'(i), 2'(i % 4), 6'(i), 8'(1 << i));
    #1;
    chk(win_full == 1'b1, "R2", "full after fill", win_full, 1);
    chk(disp_ready == 1'b0, "R2", "ready when full", disp_ready, 0);
    disp_valid = 1'b1; disp_payload = 16'hDEAD;
    @(negedge clk);
    disp_valid = 1'b0;
    #1 chk(win_full == 1'b1, "R2", "full after refused dispatch", win_full, 1);
  endtask

  task automatic t_free_order;
    complete(5, 2'd1, 6'd0);   // class 1, below its stage 2
    #1 chk(win_full == 1'b1, "R5", "class1 stage1 keeps slot", win_full, 1);
    complete(5, 2'd2, 6'd0);
    #1 chk(disp_tag == 8'h20, "R3", "slot5 freed out of order", disp_tag, 8'h20);
    complete(2, 2'd2, 6'd0);   // class 2, below its stage 3
    #1 chk(disp_tag == 8'h20, "R5", "class2 stage2 keeps slot", disp_tag, 8'h20);
    complete(2, 2'd3, 6'd0);
    #1 chk(disp_tag == 8'h04, "R3", "slot2 becomes lowest free", disp_tag, 8'h04);
    complete(0, 2'd1, 6'd0);   // class 0 at stage 1
    #1 chk(disp_tag == 8'h01, "R5", "class0 stage1 frees", disp_tag, 8'h01);
  endtask

  task automatic t_same_cycle;
    disp_valid = 1'b1; disp_payload = 16'h0200; disp_cls = 2'd3; disp_vlen = 6'd10;
    cmpl_valid = 1'b1; cmpl_tag = 8'h10; cmpl_stage = 2'd1; cmpl_elems = '0;
    @(negedge clk);
    disp_valid = 1'b0; cmpl_valid = 1'b0; cmpl_tag = '0;
    #1 chk(disp_tag == 8'h04, "R6", "dispatch landed in slot0", disp_tag, 8'h04);
    dispatch(16'h0201, 2'd0, 6'd0, 8'h04);
    #1 chk(disp_tag == 8'h10, "R6", "slot4 freed same cycle", disp_tag, 8'h10);
  endtask

  task automatic t_vector;
    complete(0, 2'd0, 6'd3);   // 10 -> 7
    complete(7, 2'd0, 6'd9);   // 7 -> 0 saturating
    #1 chk(disp_tag == 8'h10, "R4", "progress keeps slots", disp_tag, 8'h10);
  endtask

  task automatic t_save;
    logic [15:0] ep [6];
    logic [1:0]  ec [6];
    logic [5:0]  ev [6];
    ep = '{16'h0200, 16'h0101, 16'h0201, 16'h0103, 16'h0106, 16'h0107};
    ec = '{2'd3, 2'd1, 2'd0, 2'd3, 2'd2, 2'd3};
    ev = '{6'd7, 6'd1, 6'd0, 6'd3, 6'd6, 6'd0};
    irq_save = 1'b1;
    @(negedge clk);
    irq_save = 1'b0;
    cmpl_valid = 1'b1; cmpl_tag = 8'h02; cmpl_stage = 2'd3;  // R11 must be ignored
    for (int k = 0; k < 6; k++) begin
      #1;
      chk(sv_valid == 1'b1, "R7", "save beat valid", sv_valid, 1);
      chk(sv_payload == ep[k], "R7", "save payload order", sv_payload, ep[k]);
      chk(sv_vlen == ev[k] && sv_cls == ec[k], "R4", "saved class/count",
          {sv_cls, sv_vlen}, {ec[k], ev[k]});
      chk(sv_last == (k == 5), "R7", "save last flag", sv_last, (k == 5));
      chk(disp_ready == 1'b0, "R8", "ready low in save", disp_ready, 0);
      @(negedge clk);
      cmpl_valid = 1'b0; cmpl_tag = '0;
    end
    #1;
    chk(sv_valid == 1'b0, "R7", "save stream ended", sv_valid, 0);
    chk(disp_tag == 8'h01 && disp_ready == 1'b1, "R7", "window empty after save",
        {disp_ready, disp_tag}, 9'h101);
  endtask

  task automatic rs_beat(input logic [15:0] p, input logic [1:0] c,
                         input logic [5:0] v, input bit last);
    rs_valid = 1'b1; rs_payload = p; rs_cls = c; rs_vlen = v; rs_last = last;
    @(negedge clk);
    rs_valid = 1'b0; rs_last = 1'b0;
    cmpl_valid = 1'b0; cmpl_tag = '0;
  endtask

  task automatic t_restore;
    irq_restore = 1'b1;
    @(negedge clk);
    irq_restore = 1'b0;
    #1 chk(disp_ready == 1'b0, "R8", "ready low in restore", disp_ready, 0);
    rs_beat(16'h0300, 2'd1, 6'd0, 1'b0);
    cmpl_valid = 1'b1; cmpl_tag = 8'h01; cmpl_stage = 2'd3;  // R11 ignored
    rs_beat(16'h0301, 2'd3, 6'd5, 1'b0);
    rs_beat(16'h0302, 2'd0, 6'd2, 1'b1);
    #1 chk(rs_done == 1'b1, "R9", "done pulse after last", rs_done, 1);
    cmpl_valid = 1'b1; cmpl_tag = 8'h02; cmpl_stage = 2'd3; cmpl_elems = '0;  // R12
    @(negedge clk);
    cmpl_valid = 1'b0; cmpl_tag = '0;
    #1;
    chk(rs_done == 1'b0, "R9", "done lasts one cycle", rs_done, 0);
    chk(rp_valid == 1'b1 && rp_tag == 8'h01, "R10", "reissue slot0 tag",
        rp_tag, 8'h01);
    chk(rp_payload == 16'h0300, "R11", "slot0 survived completion in restore",
        rp_payload, 16'h0300);
    @(negedge clk);
    #1;
    chk(rp_tag == 8'h04 && rp_payload == 16'h0302, "R12", "freed slot1 skipped",
        rp_tag, 8'h04);
    chk(rp_vlen == 6'd2 && rp_cls == 2'd0, "R10", "reissue count/class",
        {rp_cls, rp_vlen}, {2'd0, 6'd2});
    @(negedge clk);
    #1;
    chk(rp_valid == 1'b0, "R10", "reissue ended", rp_valid, 0);
    chk(disp_tag == 8'h02 && disp_ready == 1'b1, "R10", "reissued slots stay held",
        disp_tag, 8'h02);
  endtask

  task automatic t_empty_save;
    complete(0, 2'd2, 6'd0);
    complete(2, 2'd1, 6'd0);
    irq_save = 1'b1;
    @(negedge clk);
    irq_save = 1'b0;
    #1 chk(sv_valid == 1'b0, "R7", "empty save no beats", sv_valid, 0);
    @(negedge clk);
    #1 chk(disp_ready == 1'b1 && disp_tag == 8'h01, "R7", "empty save back to idle",
           {disp_ready, disp_tag}, 9'h101);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_fill;
    t_free_order;
    t_same_cycle;
    t_vector;
    t_save;
    t_restore;
    t_empty_save;
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule